// File: doc/BRIEF.md
# Clock Alarm Edge-Capture Register

This block sits between a telecom clock synchroniser and a host. It watches four level status lines from the synchroniser: primary reference lost, secondary reference lost, PLL in holdover and PLL unlocked. Every rising and falling transition of each line sets its own sticky cause bit. A level interrupt stays asserted while any cause bit is set.

The host reaches the block through a byte-wide window of eight addresses, using a synchronous address, read strobe and write strobe. A read of the cause byte returns the captured transitions and clears them. Other addresses give the live alarm levels, the indication of which reference is in use, a writable reference-select bit that leaves the block on a pin, and a strapped interrupt-number field. A strap value of 0xF tells software that the clock hardware is absent.

Each status line, and the reference-in-use line, passes through a two-flop synchroniser before edge detection. During reset the synchroniser stages and the previous-value registers load the current input, so a line that is already high at reset produces no transition.

Top module: `clk_alarm_capture`

## Requirements
- R1: Status line i (0 primary loss, 1 secondary loss, 2 holdover, 3 unlock) sets cause bit 2i on a 0-to-1 transition and cause bit 2i+1 on a 1-to-0 transition. The bit is set within four clock edges of the input change and stays set until cleared.
- R2: A read at offset 6 returns the cause byte as it stood before the read and clears every bit of it.
- R3: A transition captured on the same clock edge as a clearing read of offset 6 leaves its cause bit set after the clear.
- R4: `irq` is high while any cause bit is set. It is low from the clock edge of a clearing read that leaves no bit set.
- R5: A read at offset 2 returns the synchronised levels in the upper nibble (unlock at bit 4, holdover at bit 5, secondary loss at bit 6, primary loss at bit 7). The lower nibble reads 0.
- R6: At offset 1, bit 3 reads the synchronised reference-in-use line. Bit 0 is a read/write reference select (0 primary, 1 secondary) that drives `ref_sel`. All other bits read 0.
- R7: A read at offset 7 returns `irq_num_strap` in the lower nibble and 0 in the upper nibble. The value 0xF is passed through unchanged.
- R8: After reset the cause byte is 0, `irq` is 0 and `ref_sel` is 0. A status line held high through reset sets no cause bit.
- R9: Read data appears on `host_rdata` on the clock edge after the read strobe is sampled and is 0 in every other cycle. Offsets 0, 3, 4 and 5 read 0. Writes to any offset other than 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register offset |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt, high while any cause bit is set |
| status_async | input | 4 | Asynchronous status lines: 0 primary loss, 1 secondary loss, 2 holdover, 3 unlock |
| cur_ref_async | input | 1 | Asynchronous reference-in-use indication |
| irq_num_strap | input | 4 | Strapped interrupt number |
| ref_sel | output | 1 | Reference select, 0 primary, 1 secondary |

## Verification
A corrupted previous-value register or cause register shows up at the next read of offset 6 as a wrong or missing bit. Because `irq` follows the cause byte, it also shows up on `irq` within one edge of the fault. A fault in the clear path is seen on the second of two back-to-back cause reads. A lost coincident transition is seen the same way. A wrong synchroniser depth or level mapping is visible in the offset 2 nibble a few cycles after an input change. The bench sweeps every line in both directions and all sixteen level patterns.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int ALM_COUNT  = 4;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 8;
  localparam int CAUSE_W    = 2 * ALM_COUNT;
  localparam int LEVEL_LSB  = DATA_W - ALM_COUNT;

  localparam logic [ADDR_W-1:0] OFF_REFCTL = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_LEVELS = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CAUSE  = 3'd6;
  localparam logic [ADDR_W-1:0] OFF_IRQNUM = 3'd7;

  localparam int REF_SEL_BIT = 0;
  localparam int CUR_REF_BIT = 3;

  typedef enum logic [1:0] {
    ALM_PRI_LOSS = 2'd0,
    ALM_SEC_LOSS = 2'd1,
    ALM_HOLDOVER = 2'd2,
    ALM_UNLOCK   = 2'd3
  } alarm_idx_e;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // Reset loads the raw input into every stage so no transition appears at release.
  always_ff @(posedge clk) begin
    stage_q[0] <= d_async;
    for (int s = 1; s < STAGES; s++) begin
      stage_q[s] <= rst ? d_async : stage_q[s-1];
    end
  end

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/alarm_edge_capture.sv
module alarm_edge_capture #(
  parameter int NUM = 4,
  localparam int CW = 2 * NUM
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] level,
  input  logic           clear_req,
  output logic [CW-1:0]  edge_hit,
  output logic [CW-1:0]  cause,
  output logic           irq
);
  logic [NUM-1:0] prev_q;
  logic [CW-1:0]  cause_q;
  logic [CW-1:0]  cause_d;
  logic           irq_q;

  genvar i;
  generate
    for (i = 0; i < NUM; i++) begin : g_edge
      assign edge_hit[2*i]   =  level[i] & ~prev_q[i];
      assign edge_hit[2*i+1] = ~level[i] &  prev_q[i];
    end
  endgenerate

  // The clear happens first, then the new transitions are ORed in, so none is lost.
  assign cause_d = (clear_req ? '0 : cause_q) | edge_hit;

  always_ff @(posedge clk) begin
    prev_q <= level;
    if (rst) begin
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      irq_q   <= |cause_d;
    end
  end

  assign cause = cause_q;
  assign irq   = irq_q;
endmodule

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import alarm_pkg::*;
#(
  parameter int NUM = ALM_COUNT,
  localparam int CW = 2 * NUM
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CW-1:0]     cause,
  input  logic [NUM-1:0]    level,
  input  logic              cur_ref,
  input  logic [3:0]        irq_num,
  output logic              clear_req,
  output logic              ref_sel,
  output logic [DATA_W-1:0] rdata
);
  logic              ref_sel_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] levels_byte;
  logic [DATA_W-1:0] refctl_byte;
  logic [DATA_W-1:0] irqnum_byte;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;

  // The primary-loss line lands in the top bit and unlock in the lowest bit of the nibble.
  genvar i;
  generate
    for (i = 0; i < NUM; i++) begin : g_lvl
      assign levels_byte[LEVEL_LSB + NUM - 1 - i] = level[i];
    end
    if (LEVEL_LSB > 0) begin : g_lvl_lo
      assign levels_byte[LEVEL_LSB-1:0] = '0;
    end
  endgenerate

  always_comb begin
    refctl_byte = '0;
    refctl_byte[CUR_REF_BIT] = cur_ref;
    refctl_byte[REF_SEL_BIT] = ref_sel_q;
  end

  assign irqnum_byte = {{(DATA_W-4){1'b0}}, irq_num};

  always_comb begin
    case (addr)
      OFF_REFCTL: rd_mux = refctl_byte;
      OFF_LEVELS: rd_mux = levels_byte;
      OFF_CAUSE:  rd_mux = DATA_W'(cause);
      OFF_IRQNUM: rd_mux = irqnum_byte;
      default:    rd_mux = '0;
    endcase
  end

  assign clear_req = rd && (addr == OFF_CAUSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sel_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (wr && addr == OFF_REFCTL) ref_sel_q <= wdata[REF_SEL_BIT];
      rdata_q <= rd ? rd_mux : '0;
    end
  end

  assign ref_sel = ref_sel_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/clk_alarm_capture.sv
module clk_alarm_capture
  import alarm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  input  logic [ALM_COUNT-1:0] status_async,
  input  logic              cur_ref_async,
  input  logic [3:0]        irq_num_strap,
  output logic              ref_sel
);
  localparam int SW = ALM_COUNT + 1;

  logic [SW-1:0]        sync_vec;
  logic [ALM_COUNT-1:0] level_s;
  logic                 cur_ref_s;
  logic [CAUSE_W-1:0]   edge_hit;
  logic [CAUSE_W-1:0]   cause_q;
  logic                 clear_req;

  alarm_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({cur_ref_async, status_async}),
    .d_sync  (sync_vec)
  );

  assign level_s   = sync_vec[ALM_COUNT-1:0];
  assign cur_ref_s = sync_vec[ALM_COUNT];

  alarm_edge_capture #(.NUM(ALM_COUNT)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .level     (level_s),
    .clear_req (clear_req),
    .edge_hit  (edge_hit),
    .cause     (cause_q),
    .irq       (irq)
  );

  alarm_regfile #(.NUM(ALM_COUNT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (host_addr),
    .rd        (host_rd),
    .wr        (host_wr),
    .wdata     (host_wdata),
    .cause     (cause_q),
    .level     (level_s),
    .cur_ref   (cur_ref_s),
    .irq_num   (irq_num_strap),
    .clear_req (clear_req),
    .ref_sel   (ref_sel),
    .rdata     (host_rdata)
  );
endmodule

// File: rtl/alarm_capture_checker.sv
module alarm_capture_checker
  import alarm_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  host_addr,
  input logic               host_rd,
  input logic               host_wr,
  input logic               irq,
  input logic               ref_sel,
  input logic [DATA_W-1:0]  host_rdata,
  input logic [CAUSE_W-1:0] edge_hit,
  input logic [CAUSE_W-1:0] cause_q
);
  // R4: the interrupt line reflects whether any cause bit is held.
  p_irq_tracks_cause_r4: assert property (@(posedge clk) disable iff (rst)
    irq == (|cause_q));

  // R1: a detected transition is held in its cause bit after the edge.
  p_edge_captured_r1: assert property (@(posedge clk) disable iff (rst)
    (|edge_hit) |=> ((cause_q & $past(edge_hit)) == $past(edge_hit)));

  // R1: without a clearing read, no captured bit is dropped.
  p_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    !(host_rd && host_addr == OFF_CAUSE) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R2 and R3: after a clearing read, only the coincident transitions remain.
  p_clear_keeps_new_r3: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == OFF_CAUSE) |=> (cause_q == $past(edge_hit)));

  // R6 and R9: the reference select moves only on a write to offset 1.
  p_refsel_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && host_addr == OFF_REFCTL) |=> $stable(ref_sel));

  // R9: read data is zero after a cycle with no read strobe.
  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> (host_rdata == '0));
endmodule

bind clk_alarm_capture alarm_capture_checker i_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .irq        (irq),
  .ref_sel    (ref_sel),
  .host_rdata (host_rdata),
  .edge_hit   (edge_hit),
  .cause_q    (cause_q)
);

// File: tb/test_clk_alarm_capture.sv
module test_clk_alarm_capture;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] host_addr = '0;
  logic       host_rd = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq;
  logic [3:0] status_async = '0;
  logic       cur_ref_async = 1'b0;
  logic [3:0] irq_num_strap = 4'h5;
  logic       ref_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clk_alarm_capture i_clk_alarm_capture (
    .clk, .rst, .host_addr, .host_rd, .host_wr, .host_wdata, .host_rdata,
    .irq, .status_async, .cur_ref_async, .irq_num_strap, .ref_sel
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    host_wdata = d;
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [7:0] lvl_byte(input logic [3:0] s);
    return {s[0], s[1], s[2], s[3], 4'b0000};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    // R8: hold the holdover line high through reset.
    status_async = 4'b0100;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    check("R8 irq after reset", {7'b0, irq}, 8'h00);
    check("R8 ref_sel after reset", {7'b0, ref_sel}, 8'h00);
    rd_reg(3'd6, d); check("R8 no cause from high-at-reset line", d, 8'h00);
    check("R9 rdata idle", host_rdata, 8'h00);

    // R1/R2/R4: sweep every line in both directions.
    status_async = 4'b0000;
    settle();
    rd_reg(3'd6, d); check("R1 holdover fall", d, 8'h20);
    for (int i = 0; i < 4; i++) begin
      status_async[i] = 1'b1;
      settle();
      check("R4 irq high with cause", {7'b0, irq}, 8'h01);
      rd_reg(3'd6, d); check("R1 rising bit", d, 8'(1 << (2*i)));
      check("R4 irq low after clear", {7'b0, irq}, 8'h00);
      rd_reg(3'd6, d); check("R2 cleared", d, 8'h00);
      status_async[i] = 1'b0;
      settle();
      rd_reg(3'd6, d); check("R1 falling bit", d, 8'(1 << (2*i+1)));
    end

    // R1: simultaneous rises then falls on all lines, plus stickiness over time.
    status_async = 4'hF;
    settle(); settle();
    rd_reg(3'd6, d); check("R1 all rising", d, 8'h55);
    status_async = 4'h0;
    settle();
    rd_reg(3'd6, d); check("R1 all falling", d, 8'hAA);

    // R5: all sixteen level patterns.
    for (int p = 0; p < 16; p++) begin
      status_async = 4'(p);
      settle();
      rd_reg(3'd2, d); check("R5 live levels", d, lvl_byte(4'(p)));
    end
    status_async = 4'h0;
    settle();
    rd_reg(3'd6, d);
    check("R4 irq low after sweep clear", {7'b0, irq}, 8'h00);

    // R3: a transition captured on the clearing edge survives.
    status_async[0] = 1'b1;
    settle();
    @(negedge clk);
    status_async[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    host_addr = 3'd6;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    check("R3 first read old bits", host_rdata, 8'h01);
    check("R3 irq stays high", {7'b0, irq}, 8'h01);
    rd_reg(3'd6, d); check("R3 coincident bit kept", d, 8'h40);
    status_async = 4'h0;
    settle();
    rd_reg(3'd6, d);

    // R6: reference select and in-use indication.
    wr_reg(3'd1, 8'hFF);
    check("R6 ref_sel set", {7'b0, ref_sel}, 8'h01);
    rd_reg(3'd1, d); check("R6 readback sel", d, 8'h01);
    cur_ref_async = 1'b1;
    settle();
    rd_reg(3'd1, d); check("R6 cur ref bit", d, 8'h09);
    wr_reg(3'd1, 8'h00);
    rd_reg(3'd1, d); check("R6 sel cleared", d, 8'h08);

    // R9: writes elsewhere ignored, unused offsets read 0.
    wr_reg(3'd0, 8'h01); wr_reg(3'd6, 8'hFF); wr_reg(3'd7, 8'hFF);
    check("R9 stray write ref_sel", {7'b0, ref_sel}, 8'h00);
    rd_reg(3'd6, d); check("R9 stray write cause", d, 8'h00);
    for (int a = 0; a < 6; a++) begin
      if (a == 1 || a == 2) continue;
      rd_reg(3'(a), d); check("R9 unused offset", d, 8'h00);
    end

    // R7: strap readback including the absent-hardware code.
    rd_reg(3'd7, d); check("R7 irq number", d, 8'h05);
    irq_num_strap = 4'hF;
    rd_reg(3'd7, d); check("R7 absent code", d, 8'h0F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule